// File: doc/BRIEF.md
# Convertible J-K/D Register Bank

This block is a bank of identical register cells meant to sit behind a product-term array. Each cell's flip-flop takes its J and K drive from two logic terms. Together these give hold, set, clear and toggle behaviour. A per-cell fold term switches the cell into D operation while the design is running. It does this by steering the inverse of J onto the K input, so that the flop takes the value of J at the next rising edge.

Each cell also has a load term, which captures the value seen on its own pad. With the load term the register can act as an input register on a bidirectional bus. A clear term and a preset term act asynchronously on the flop. A synchronous active-low power-on reset brings every register to zero. The registered value always feeds back to the array. It reaches the pad through a tristate driver. That driver is enabled only when the cell's own enable term is active and the shared active-low enable pin is low.

Top module: `cjk_reg_bank`

## Requirements
- R1: On a rising clock edge with rst_n high and the cell's fold, load, clear and preset terms low, the cell follows the J/K table given as {j,k}: 00 holds, 10 sets to 1, 01 clears to 0, and 11 inverts the stored bit.
- R2: When the cell's fold term is high and load is low, K is replaced by the inverse of J, and the cell stores J at the rising edge (D operation), whatever the K term is.
- R3: When the cell's load term is high, the rising edge stores the cell's pad_in bit, taking priority over J, K and fold.
- R4: A high clear term forces the cell's stored bit to 0 at once, without waiting for a clock edge, and holds it there while asserted.
- R5: A high preset term with clear low forces the stored bit to 1 at once, without a clock edge.
- R6: When clear and preset are both high, the cell reads 0.
- R7: With rst_n low at a rising edge and no clear or preset active, every cell stores 0, overriding load and J/K.
- R8: pad_oe of a cell is high only when its oe_term is high and oe_pin_n is low. pad_out always carries the stored bit.
- R9: With pad_oe low, the register still updates from its terms, and q_fb still shows the stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; cells update on the rising edge |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| j_term | input | CELLS | J drive, one bit per cell |
| k_term | input | CELLS | K drive, one bit per cell |
| fold_term | input | CELLS | High selects D operation (K = not J) |
| load_term | input | CELLS | High captures pad_in at the edge |
| preset_term | input | CELLS | Asynchronous set, active high |
| clear_term | input | CELLS | Asynchronous clear, active high, wins over preset |
| oe_term | input | CELLS | Per-cell output enable term |
| oe_pin_n | input | 1 | Shared active-low output enable pin |
| pad_in | input | CELLS | Value observed on each cell's pad |
| q_fb | output | CELLS | Stored bits fed back to the array |
| pad_out | output | CELLS | Data toward each pad driver |
| pad_oe | output | CELLS | Drive enable for each pad |

## Verification
Results from J, K, fold, load and the power-on reset appear on q_fb after exactly one rising edge. The bench therefore changes inputs at a falling edge and compares q_fb at the following falling edge. Its reference model is stepped once per edge. Clear and preset act without a clock, so their effect is sampled one nanosecond after they are applied, before any edge. They are then held across an edge and released at a falling edge. pad_oe and pad_out are combinational, and they are compared one nanosecond after each input change.

// File: rtl/cjk_pkg.sv
// Package: shared J/K operation encoding and the next-state function.
// Assumes: the operation code is the pair {j, k_effective}.
package cjk_pkg;

    typedef enum logic [1:0] {
        JK_HOLD   = 2'b00,
        JK_CLEAR  = 2'b01,
        JK_SET    = 2'b10,
        JK_TOGGLE = 2'b11
    } jk_op_e;

    // Next stored value for a given J/K operation and current value.
    function automatic logic jk_apply(input jk_op_e op, input logic cur);
        logic res;
        case (op)
            JK_HOLD:   res = cur;
            JK_CLEAR:  res = 1'b0;
            JK_SET:    res = 1'b1;
            default:   res = ~cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/cjk_steer.sv
// Module: steering logic for one cell. It picks the effective K (folded or
// not), decodes the J/K operation and applies the load override.
// Assumes: load has priority over the J/K path; purely combinational.
module cjk_steer
    import cjk_pkg::*;
(
    input  logic j_in,
    input  logic k_in,
    input  logic fold,
    input  logic load,
    input  logic din,
    input  logic cur,
    output logic nxt
);
    logic   k_eff;
    jk_op_e op;

    // Fold-back path: D operation drives K with the inverse of J.
    always_comb k_eff = fold ? ~j_in : k_in;

    // Operation decode and load override.
    always_comb begin
        op  = jk_op_e'({j_in, k_eff});
        nxt = load ? din : jk_apply(op, cur);
    end
endmodule

// File: rtl/cjk_cell.sv
// Module: one register cell. Its flop has asynchronous clear and preset
// (clear wins) and a synchronous active-low reset applied on the clock edge.
// Assumes: clr/pre are glitch-free terms; rst_n is synchronous to clk.
module cjk_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic j_in,
    input  logic k_in,
    input  logic fold,
    input  logic load,
    input  logic din,
    input  logic clr,
    input  logic pre,
    output logic q
);
    logic nxt;

    cjk_steer i_steer (
        .j_in (j_in),
        .k_in (k_in),
        .fold (fold),
        .load (load),
        .din  (din),
        .cur  (q),
        .nxt  (nxt)
    );

    // Storage: async clear over async preset, then sync reset, then next state.
    always_ff @(posedge clk or posedge clr or posedge pre) begin
        if (clr)         q <= 1'b0;
        else if (pre)    q <= 1'b1;
        else if (!rst_n) q <= 1'b0;
        else             q <= nxt;
    end
endmodule

// File: rtl/cjk_outctl.sv
// Module: pad output control for the bank. Each enable combines its own
// term with the shared active-low pin.
// Assumes: the pad driver itself lives outside this block.
module cjk_outctl #(
    parameter int CELLS = 8
) (
    input  logic [CELLS-1:0] q,
    input  logic [CELLS-1:0] oe_term,
    input  logic             oe_pin_n,
    output logic [CELLS-1:0] pad_out,
    output logic [CELLS-1:0] pad_oe
);
    // Data always follows the register; the enable gates the driver.
    always_comb begin
        pad_out = q;
        pad_oe  = oe_term & {CELLS{~oe_pin_n}};
    end
endmodule

// File: rtl/cjk_reg_bank.sv
// Module: top of the convertible J-K/D register bank. It holds CELLS
// register cells plus the output control.
// Assumes: all terms come from an external product-term array.
module cjk_reg_bank #(
    parameter int CELLS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CELLS-1:0] j_term,
    input  logic [CELLS-1:0] k_term,
    input  logic [CELLS-1:0] fold_term,
    input  logic [CELLS-1:0] load_term,
    input  logic [CELLS-1:0] preset_term,
    input  logic [CELLS-1:0] clear_term,
    input  logic [CELLS-1:0] oe_term,
    input  logic             oe_pin_n,
    input  logic [CELLS-1:0] pad_in,
    output logic [CELLS-1:0] q_fb,
    output logic [CELLS-1:0] pad_out,
    output logic [CELLS-1:0] pad_oe
);
    // One cell per bit.
    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        cjk_cell i_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .j_in  (j_term[c]),
            .k_in  (k_term[c]),
            .fold  (fold_term[c]),
            .load  (load_term[c]),
            .din   (pad_in[c]),
            .clr   (clear_term[c]),
            .pre   (preset_term[c]),
            .q     (q_fb[c])
        );
    end

    cjk_outctl #(.CELLS(CELLS)) i_outctl (
        .q        (q_fb),
        .oe_term  (oe_term),
        .oe_pin_n (oe_pin_n),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );
endmodule

// File: rtl/cjk_reg_bank_chk.sv
// Module: assertion checker for cjk_reg_bank, attached with bind.
// Assumes: clear/preset are held across any clock edge they overlap.
module cjk_reg_bank_chk #(
    parameter int CELLS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CELLS-1:0] j_term,
    input logic [CELLS-1:0] k_term,
    input logic [CELLS-1:0] fold_term,
    input logic [CELLS-1:0] load_term,
    input logic [CELLS-1:0] preset_term,
    input logic [CELLS-1:0] clear_term,
    input logic [CELLS-1:0] oe_term,
    input logic             oe_pin_n,
    input logic [CELLS-1:0] pad_in,
    input logic [CELLS-1:0] q_fb,
    input logic [CELLS-1:0] pad_out,
    input logic [CELLS-1:0] pad_oe
);
    logic armed = 1'b0;

    // Arm the checks once a first edge has given $past a defined history.
    always_ff @(posedge clk) armed <= 1'b1;

    logic [CELLS-1:0] async_now;
    always_comb async_now = clear_term | preset_term;

    // R1: plain J/K table on cells with no fold, load or async term.
    assert_jk_table_R1: assert property (@(posedge clk) disable iff (!armed)
        $past(rst_n) |->
        ((q_fb ^ (($past(j_term) & ~$past(q_fb)) | (~$past(k_term) & $past(q_fb))))
         & $past(~(load_term | fold_term | clear_term | preset_term)) & ~async_now) == '0);

    // R2: folded cells store J.
    assert_fold_d_R2: assert property (@(posedge clk) disable iff (!armed)
        $past(rst_n) |->
        ((q_fb ^ $past(j_term))
         & $past(fold_term & ~load_term & ~clear_term & ~preset_term) & ~async_now) == '0);

    // R3: loading cells store their pad value.
    assert_load_R3: assert property (@(posedge clk) disable iff (!armed)
        $past(rst_n) |->
        ((q_fb ^ $past(pad_in)) & $past(load_term & ~clear_term & ~preset_term)
         & ~async_now) == '0);

    // R4 and R6: a clear term always shows as a zero.
    assert_clear_R4: assert property (@(posedge clk) disable iff (!armed)
        (clear_term & q_fb) == '0);

    // R5: preset without clear shows as a one.
    assert_preset_R5: assert property (@(posedge clk) disable iff (!armed)
        (preset_term & ~clear_term & ~q_fb) == '0);

    // R7: power-on reset zeroes cells free of async terms.
    assert_por_R7: assert property (@(posedge clk) disable iff (!armed)
        !$past(rst_n) |-> ((q_fb & $past(~(clear_term | preset_term)) & ~async_now) == '0));

    // R8: the shared pin disables every driver.
    assert_oe_pin_R8: assert property (@(posedge clk) disable iff (!armed)
        oe_pin_n |-> pad_oe == '0);

    // R9: pad data keeps following the register whatever the enable.
    assert_pad_data_R9: assert property (@(posedge clk) disable iff (!armed)
        pad_out == q_fb);

    // Per-cell enable needs its term.
    assert_oe_term_R8: assert property (@(posedge clk) disable iff (!armed)
        (pad_oe & ~oe_term) == '0);
endmodule

bind cjk_reg_bank cjk_reg_bank_chk #(.CELLS(CELLS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .j_term      (j_term),
    .k_term      (k_term),
    .fold_term   (fold_term),
    .load_term   (load_term),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .oe_term     (oe_term),
    .oe_pin_n    (oe_pin_n),
    .pad_in      (pad_in),
    .q_fb        (q_fb),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe)
);

// File: tb/test_cjk_reg_bank.sv
// Bench: seeded random steps plus directed corner cases, checked against a
// bench-side model of the requirements.
module test_cjk_reg_bank;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] j_term, k_term, fold_term, load_term;
    logic [W-1:0] preset_term, clear_term, oe_term, pad_in;
    logic         oe_pin_n;
    logic [W-1:0] q_fb, pad_out, pad_oe;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] exp_q;
    int unsigned seed_dummy;

    always #2.5 clk = ~clk;

    cjk_reg_bank #(.CELLS(W)) i_cjk_reg_bank (
        .clk(clk), .rst_n(rst_n), .j_term(j_term), .k_term(k_term),
        .fold_term(fold_term), .load_term(load_term),
        .preset_term(preset_term), .clear_term(clear_term),
        .oe_term(oe_term), .oe_pin_n(oe_pin_n), .pad_in(pad_in),
        .q_fb(q_fb), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Reference next state built from R1, R2 and R3.
    function automatic logic [W-1:0] model(input logic [W-1:0] q, j, k, fold, load, din);
        logic [W-1:0] ke, jk;
        ke = (fold & ~j) | (~fold & k);
        jk = (j & ~q) | (~ke & q);
        return (load & din) | (~load & jk);
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One synchronous step: drive at a falling edge, check outputs.
    task automatic step(input string tag, input logic [W-1:0] j, k, fold, load, din, oe,
                        input logic oen);
        j_term = j; k_term = k; fold_term = fold; load_term = load;
        pad_in = din; oe_term = oe; oe_pin_n = oen;
        #1;
        chk("R8 enable", pad_oe, oe & {W{~oen}});
        chk("R8 data", pad_out, q_fb);
        exp_q = model(exp_q, j, k, fold, load, din);
        @(negedge clk);
        chk(tag, q_fb, exp_q);
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h1F00_5EED);
        rst_n = 1'b0; j_term = '1; k_term = '0; fold_term = '0; load_term = '1;
        preset_term = '0; clear_term = '0; oe_term = '0; oe_pin_n = 1'b1; pad_in = '1;
        repeat (3) @(negedge clk);
        exp_q = '0;
        chk("R7 reset state", q_fb, '0);
        rst_n = 1'b1;

        // R1 directed: set, hold, toggle twice, clear.
        step("R1 set",    8'hA5, 8'h00, '0, '0, '0, '1, 1'b0);
        step("R1 hold",   8'h00, 8'h00, '0, '0, '0, '1, 1'b0);
        step("R1 toggle", 8'hFF, 8'hFF, '0, '0, '0, '1, 1'b0);
        step("R1 toggle", 8'hFF, 8'hFF, '0, '0, '0, '1, 1'b0);
        step("R1 clear",  8'h00, 8'h0F, '0, '0, '0, '1, 1'b0);
        // R2: fold makes D operation regardless of K.
        step("R2 fold",   8'h3C, 8'hFF, '1, '0, '0, '1, 1'b0);
        step("R2 fold",   8'hC3, 8'h00, '1, '0, '0, '1, 1'b0);
        // R3: load beats J/K and fold.
        step("R3 load",   8'hFF, 8'h00, 8'h0F, '1, 8'h96, '1, 1'b0);
        // R9: disabled outputs, register still updates.
        step("R9 disabled update", 8'h00, 8'h00, '0, '1, 8'h5A, '1, 1'b1);
        step("R9 disabled toggle", 8'hFF, 8'hFF, '0, '0, '0, 8'h33, 1'b1);
        chk("R9 feedback", q_fb, exp_q);

        // R4: asynchronous clear without a clock.
        j_term = '0; k_term = '0; fold_term = '0; load_term = '0; exp_q = 8'hFF;
        step("R1 set all", 8'hFF, 8'h00, '0, '0, '0, '1, 1'b0);
        j_term = '0; clear_term = 8'h0F;
        #1 chk("R4 async clear", q_fb, 8'hF0);
        exp_q = 8'hF0;
        @(negedge clk) chk("R4 held", q_fb, exp_q);
        clear_term = '0;
        // R5: asynchronous preset.
        preset_term = 8'h0C;
        #1 chk("R5 async preset", q_fb, 8'hFC);
        exp_q = 8'hFC;
        @(negedge clk) chk("R5 held", q_fb, exp_q);
        preset_term = '0;
        // R6: both asserted, clear wins.
        clear_term = 8'h3C; preset_term = 8'h3C;
        #1 chk("R6 clear wins", q_fb, 8'hC0);
        exp_q = 8'hC0;
        @(negedge clk) chk("R6 held", q_fb, exp_q);
        clear_term = '0; preset_term = '0;
        @(negedge clk) chk("R6 released", q_fb, exp_q);

        // R7: mid-run synchronous reset overrides J and load.
        j_term = '1; load_term = 8'h0F; pad_in = '1; rst_n = 1'b0;
        @(negedge clk) chk("R7 sync reset", q_fb, '0);
        exp_q = '0; rst_n = 1'b1; load_term = '0; j_term = '0;

        // Random steps across R1, R2, R3, R8 and R9.
        for (int n = 0; n < 400; n++) begin
            step("R1 R2 R3 random", W'($urandom), W'($urandom), W'($urandom & $urandom),
                 W'($urandom & $urandom & $urandom), W'($urandom), W'($urandom),
                 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule